// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a framebuffer in memory and turns it into a stream of read burst requests for the display fetch path. Software programs a start byte address, the number of bytes to fetch on each line, the byte stride between the starts of consecutive lines, the number of lines less one, and a ceiling on the number of requests that may be in flight. The stride is independent of the fetched length, so lines that carry padding at their ends can be skipped over.

When a frame start pulse arrives, the programmed values are captured into a private copy, and the walk begins at the start address. Each line is cut into bursts of at most 16 beats. A beat is 4 bytes, so line lengths must be a non-zero multiple of 4. The last burst of a line carries only the beats that remain. A line ends, the walker moves to the previous line start plus the stride, and it stops once the programmed number of lines has been issued. Requests use a plain valid/grant handshake. A separate completion pulse returns one credit to the in-flight counter. Response data, pixel handling and the bus protocol itself sit outside this block.

Top module: `fb_scan_addrgen`

## Requirements
- R1: After reset, `req_valid` and `frame_busy` are both 0.
- R2: Configuration inputs are captured only on the clock edge where `frame_start` is 1. Changes made to them during a frame do not alter any address, beat count, line count or in-flight limit of that frame.
- R3: In the cycle after a `frame_start` edge, `frame_busy` is 1 and `req_addr` equals the captured start address. `req_valid` is also 1 when the in-flight count is below the limit.
- R4: A line of L bytes is split into bursts of 16 beats (a beat is 4 bytes), issued in address order. The address rises by 64 bytes from one burst to the next. The last burst of the line carries (L/4) mod 16 beats, or 16 when that remainder is 0. `req_beats` is always between 1 and 16 while `req_valid` is 1.
- R5: The first burst of each line after the first one starts at the previous line's start address plus the captured stride.
- R6: Exactly (line count field + 1) lines are issued. After the last burst is granted, `frame_busy` falls and `req_valid` stays 0 until the next `frame_start`.
- R7: A request is accepted when `req_valid` and `req_grant` are both 1 on a clock edge. The in-flight count rises by one for each accepted request and falls by one for each `rsp_done` pulse. `req_valid` is 0 whenever the count equals the captured limit. A `rsp_done` pulse with nothing in flight is ignored.
- R8: While `req_valid` is 1 and `req_grant` is 0, the request stays posted: `req_addr` and `req_beats` hold unchanged into the next cycle.
- R9: A `frame_start` pulse that arrives while a frame is still being walked abandons the remaining bursts. The walk restarts from the newly captured start address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Byte address of the first pixel of the frame |
| cfg_len_bytes | input | LEN_W | Bytes fetched per line, a non-zero multiple of 4 |
| cfg_pitch | input | ADDR_W | Byte stride from one line start to the next |
| cfg_lines_m1 | input | LINES_W | Number of lines minus one |
| cfg_max_out | input | OUT_W | Ceiling on requests in flight, at least 1 |
| frame_start | input | 1 | One-cycle pulse that captures the configuration and starts a walk |
| req_valid | output | 1 | A burst request is posted |
| req_addr | output | ADDR_W | Byte address of the posted burst |
| req_beats | output | BEATS_W | Beat count of the posted burst, 1 to 16 |
| req_grant | input | 1 | Downstream accepts the posted request |
| rsp_done | input | 1 | One previously accepted request has completed |
| frame_busy | output | 1 | A frame walk is in progress |

## Verification
Four properties are checked on every cycle:
- a posted request holds its address and beat count until it is granted;
- the beat count stays between 1 and 16;
- no request is accepted once the in-flight count has reached the limit;
- a frame start is followed by a busy walker that sits at the start address.

Other behaviours only show up across whole scenarios, and the bench's scoreboard covers them:
- the exact order of burst addresses;
- the shortened last burst of each line;
- the step to the next line by the stride;
- the exact number of lines;
- the way captured settings ignore changes made in mid-frame;
- the restart on an early frame start.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_e;

endpackage

// File: rtl/fbs_cfg_shadow.sv
module fbs_cfg_shadow #(
   parameter int ADDR_W         = 32,
   parameter int LEN_W          = 16,
   parameter int LINES_W        = 12,
   parameter int OUT_W          = 4,
   parameter bit SEPARATE_PITCH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  in_pitch,
   input  logic [LEN_W-1:0]   in_len,
   input  logic [LINES_W-1:0] in_lines_m1,
   input  logic [OUT_W-1:0]   in_max_out,
   output logic [ADDR_W-1:0]  sh_pitch,
   output logic [LEN_W-1:0]   sh_len,
   output logic [LINES_W-1:0] sh_lines_m1,
   output logic [OUT_W-1:0]   sh_max_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_len      <= '0;
         sh_lines_m1 <= '0;
         sh_max_out  <= '0;
      end else if (load) begin
         sh_len      <= in_len;
         sh_lines_m1 <= in_lines_m1;
         sh_max_out  <= in_max_out;
      end
   end

   generate
      if (SEPARATE_PITCH) begin : g_pitch_reg
         logic [ADDR_W-1:0] pitch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pitch_q <= '0;
            else if (load) pitch_q <= in_pitch;
         end
         assign sh_pitch = pitch_q;
      end else begin : g_pitch_packed
         logic unused_pitch;
         assign unused_pitch = ^in_pitch;
         assign sh_pitch     = ADDR_W'(sh_len);
      end
   endgenerate

endmodule

// File: rtl/fbs_credit.sv
module fbs_credit #(
   parameter int OUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W-1:0] limit,
   input  logic             take,
   input  logic             give,
   output logic             room
);

   logic [OUT_W-1:0] inflight_q;
   logic             give_ok;

   assign give_ok = give && (inflight_q != '0);
   assign room    = inflight_q < limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight_q <= '0;
      end else begin
         case ({take, give_ok})
            2'b10:   inflight_q <= inflight_q + 1'b1;
            2'b01:   inflight_q <= inflight_q - 1'b1;
            default: inflight_q <= inflight_q;
         endcase
      end
   end

   // R7: a request is never accepted when the credit pool is empty
   p_take_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (inflight_q < limit));

endmodule

// File: rtl/fbs_walker.sv
module fbs_walker
   import fbs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINES_W    = 12,
   parameter int BEAT_BYTES = 4,
   parameter int MAX_BEATS  = 16,
   localparam int BEAT_SH   = $clog2(BEAT_BYTES),
   localparam int BEATS_W   = $clog2(MAX_BEATS) + 1,
   localparam int BURST_B   = MAX_BEATS * BEAT_BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [ADDR_W-1:0]  start_base,
   input  logic [LEN_W-1:0]   start_len,
   input  logic               adv,
   input  logic [ADDR_W-1:0]  run_pitch,
   input  logic [LEN_W-1:0]   run_len,
   input  logic [LINES_W-1:0] run_lines_m1,
   output logic               active,
   output logic [ADDR_W-1:0]  addr,
   output logic [BEATS_W-1:0] beats
);

   walk_state_e        state_q;
   logic [ADDR_W-1:0]  line_addr_q;
   logic [ADDR_W-1:0]  cur_addr_q;
   logic [LEN_W-1:0]   rem_q;
   logic [LINES_W-1:0] line_idx_q;
   logic               line_tail;
   logic               frame_tail;
   logic [ADDR_W-1:0]  next_line;

   assign active     = (state_q == WALK_RUN);
   assign addr       = cur_addr_q;
   assign line_tail  = (rem_q <= LEN_W'(MAX_BEATS));
   assign frame_tail = line_tail && (line_idx_q == run_lines_m1);
   assign beats      = line_tail ? BEATS_W'(rem_q) : BEATS_W'(MAX_BEATS);
   assign next_line  = line_addr_q + run_pitch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= WALK_IDLE;
         line_addr_q <= '0;
         cur_addr_q  <= '0;
         rem_q       <= '0;
         line_idx_q  <= '0;
      end else if (start) begin
         state_q     <= WALK_RUN;
         line_addr_q <= start_base;
         cur_addr_q  <= start_base;
         rem_q       <= start_len >> BEAT_SH;
         line_idx_q  <= '0;
      end else if (active && adv) begin
         if (!line_tail) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(BURST_B);
            rem_q      <= rem_q - LEN_W'(MAX_BEATS);
         end else if (frame_tail) begin
            state_q <= WALK_IDLE;
         end else begin
            line_addr_q <= next_line;
            cur_addr_q  <= next_line;
            rem_q       <= run_len >> BEAT_SH;
            line_idx_q  <= line_idx_q + 1'b1;
         end
      end
   end

   // R3: a start pulse puts the walker on the new base address
   p_start_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active && (addr == $past(start_base))));

   // R4: a busy walker always offers a legal burst size
   p_beats_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((beats != '0) && (beats <= BEATS_W'(MAX_BEATS))));

   // R6: the granted last burst of the last line ends the walk
   p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && adv && frame_tail && !start) |=> !active);

endmodule

// File: rtl/fb_scan_addrgen.sv
module fb_scan_addrgen
   import fbs_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int LEN_W          = 16,
   parameter int LINES_W        = 12,
   parameter int OUT_W          = 4,
   parameter int BEAT_BYTES     = 4,
   parameter int MAX_BEATS      = 16,
   parameter bit SEPARATE_PITCH = 1'b1,
   localparam int BEATS_W       = $clog2(MAX_BEATS) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [LEN_W-1:0]   cfg_len_bytes,
   input  logic [ADDR_W-1:0]  cfg_pitch,
   input  logic [LINES_W-1:0] cfg_lines_m1,
   input  logic [OUT_W-1:0]   cfg_max_out,
   input  logic               frame_start,
   output logic               req_valid,
   output logic [ADDR_W-1:0]  req_addr,
   output logic [BEATS_W-1:0] req_beats,
   input  logic               req_grant,
   input  logic               rsp_done,
   output logic               frame_busy
);

   generate
      if ((BEAT_BYTES < 1) || ((BEAT_BYTES & (BEAT_BYTES - 1)) != 0)) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two");
      end
      if ((MAX_BEATS < 1) || ((MAX_BEATS & (MAX_BEATS - 1)) != 0)) begin : g_bad_burst
         $error("MAX_BEATS must be a power of two");
      end
      if (LEN_W <= $clog2(BEAT_BYTES)) begin : g_bad_len
         $error("LEN_W too narrow for one beat");
      end
      if (OUT_W < 1) begin : g_bad_out
         $error("OUT_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0]  sh_pitch;
   logic [LEN_W-1:0]   sh_len;
   logic [LINES_W-1:0] sh_lines_m1;
   logic [OUT_W-1:0]   sh_max_out;
   logic               walk_active;
   logic               credit_room;
   logic               accept;

   fbs_cfg_shadow #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINES_W(LINES_W), .OUT_W(OUT_W),
      .SEPARATE_PITCH(SEPARATE_PITCH)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(frame_start),
      .in_pitch(cfg_pitch), .in_len(cfg_len_bytes),
      .in_lines_m1(cfg_lines_m1), .in_max_out(cfg_max_out),
      .sh_pitch(sh_pitch), .sh_len(sh_len),
      .sh_lines_m1(sh_lines_m1), .sh_max_out(sh_max_out)
   );

   fbs_walker #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINES_W(LINES_W),
      .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(frame_start),
      .start_base(cfg_base), .start_len(cfg_len_bytes),
      .adv(accept), .run_pitch(sh_pitch), .run_len(sh_len),
      .run_lines_m1(sh_lines_m1),
      .active(walk_active), .addr(req_addr), .beats(req_beats)
   );

   fbs_credit #(
      .OUT_W(OUT_W)
   ) u_credit (
      .clk(clk), .rst_n(rst_n), .limit(sh_max_out),
      .take(accept), .give(rsp_done), .room(credit_room)
   );

   assign req_valid  = walk_active && credit_room;
   assign accept     = req_valid && req_grant;
   assign frame_busy = walk_active;

   // R8: a posted but ungranted request stays put
   p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_grant && !frame_start) |=>
         (req_valid && $stable(req_addr) && $stable(req_beats)));

endmodule

// File: tb/tb_fb_scan_addrgen.sv
module tb_fb_scan_addrgen;

   localparam int AW = 32;
   localparam int LW = 16;
   localparam int NW = 12;
   localparam int OW = 4;
   localparam int BW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [LW-1:0] cfg_len_bytes = '0;
   logic [AW-1:0] cfg_pitch = '0;
   logic [NW-1:0] cfg_lines_m1 = '0;
   logic [OW-1:0] cfg_max_out = '0;
   logic          frame_start = 1'b0;
   logic          req_valid;
   logic [AW-1:0] req_addr;
   logic [BW-1:0] req_beats;
   logic          req_grant = 1'b0;
   logic          rsp_done = 1'b0;
   logic          frame_busy;

   int checks = 0;
   int errors = 0;
   logic [AW+BW-1:0] expq [$];
   logic          grant_en = 1'b0;
   logic          done_en = 1'b1;
   int            outs = 0;
   int            lim = 0;
   logic [15:0]   lfsr = 16'hACE1;

   always #4 clk = ~clk;

   fb_scan_addrgen dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len_bytes(cfg_len_bytes),
      .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1), .cfg_max_out(cfg_max_out),
      .frame_start(frame_start), .req_valid(req_valid), .req_addr(req_addr),
      .req_beats(req_beats), .req_grant(req_grant), .rsp_done(rsp_done),
      .frame_busy(frame_busy)
   );

   task automatic chk(input string req, input logic ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver side of the scoreboard: expected bursts for one frame (R4, R5, R6)
   task automatic push_frame(input logic [AW-1:0] base, input int len, input logic [AW-1:0] pitch,
                             input int lm1);
      for (int l = 0; l <= lm1; l++) begin
         logic [AW-1:0] a;
         int rem;
         a   = base + AW'(l) * pitch;
         rem = len / 4;
         while (rem > 0) begin
            int b;
            b = (rem > 16) ? 16 : rem;
            expq.push_back({a, BW'(b)});
            a   = a + AW'(b * 4);
            rem = rem - b;
         end
      end
   endtask

   // monitor: drives grant/done, then pops and compares accepted requests
   always @(negedge clk) begin
      #1;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_grant = grant_en && !frame_start && (lfsr[0] || lfsr[3]);
      rsp_done  = (outs > 0) && (lfsr[5] || !done_en) && done_en;
      #1;
      if (rst_n) begin
         if (outs >= lim && lim > 0)
            chk("R7 valid low at limit", !req_valid, req_valid, 0);
         if (req_valid && req_grant) begin
            logic [AW+BW-1:0] e;
            if (expq.size() == 0) begin
               chk("R6 no extra request", 1'b0, {req_addr, req_beats}, 0);
            end else begin
               e = expq.pop_front();
               chk("R4 R5 burst addr/beats", {req_addr, req_beats} == e,
                   {req_addr, req_beats}, e);
            end
            outs++;
         end
         if (rsp_done) outs--;
      end
   end

   task automatic start_frame(input logic [AW-1:0] base, input int len, input logic [AW-1:0] pitch,
                              input int lm1, input int mo);
      @(negedge clk);
      cfg_base = base; cfg_len_bytes = LW'(len); cfg_pitch = pitch;
      cfg_lines_m1 = NW'(lm1); cfg_max_out = OW'(mo);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      lim = mo;
      // R2: scramble the inputs right after capture
      cfg_base = 32'hDEAD_0000; cfg_len_bytes = 16'd8; cfg_pitch = 32'h10;
      cfg_lines_m1 = '0; cfg_max_out = OW'(1);
      #3;
      chk("R3 busy after start", frame_busy == 1'b1, frame_busy, 1);
      chk("R3 first addr", req_addr == base, req_addr, base);
   endtask

   task automatic finish_frame(input string tag);
      int t;
      t = 0;
      while ((expq.size() != 0 || frame_busy) && t < 5000) begin
         @(negedge clk); t++;
      end
      chk({tag, " all bursts seen"}, expq.size() == 0, expq.size(), 0);
      repeat (3) @(negedge clk);
      #3;
      chk("R6 busy low after last line", !frame_busy, frame_busy, 0);
      chk("R6 valid low after frame", !req_valid, req_valid, 0);
      t = 0;
      while (outs != 0 && t < 1000) begin @(negedge clk); t++; end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #3;
      chk("R1 valid after reset", !req_valid, req_valid, 0);
      chk("R1 busy after reset", !frame_busy, frame_busy, 0);
      rst_n = 1'b1;

      // padded stride, 50 beats per line -> 16,16,16,2 ; limit 2
      push_frame(32'h1000, 200, 32'h100, 3);
      grant_en = 1'b1;
      start_frame(32'h1000, 200, 32'h100, 3, 2);
      finish_frame("R2 R4 R5 padded");

      // single line, exactly one full burst, limit 1
      push_frame(32'h8000, 64, 32'h40, 0);
      start_frame(32'h8000, 64, 32'h40, 0, 1);
      finish_frame("R4 R6 one burst");

      // one beat per line, large stride, limit 4
      push_frame(32'h0002_0000, 4, 32'h1000, 5);
      start_frame(32'h0002_0000, 4, 32'h1000, 5, 4);
      finish_frame("R5 tiny lines");

      // R8 and R9: hold request, then restart mid-frame
      grant_en = 1'b0;
      push_frame(32'h3000, 128, 32'h80, 2);
      start_frame(32'h3000, 128, 32'h80, 2, 3);
      repeat (3) @(negedge clk);
      #3;
      chk("R8 held addr", req_addr == 32'h3000 && req_valid, req_addr, 32'h3000);
      chk("R8 held beats", req_beats == 5'd16, req_beats, 16);
      expq.delete();
      push_frame(32'h0005_0000, 72, 32'h60, 1);
      start_frame(32'h0005_0000, 72, 32'h60, 1, 3);
      grant_en = 1'b1;
      finish_frame("R9 restart");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule